// File: doc/BRIEF.md
# Qualified General-Purpose I/O Port

A sixteen-pin I/O port slice controlled through a small register bank. Every pin can be handed to a peripheral or kept under software control. In software mode a direction bit enables the output driver, and a per-pin output latch supplies the driven level. Software can write the latch whole, or change chosen bits by writing ones to separate set, clear and toggle registers. Bits written as zero are left alone, so no read-modify-write is needed.

Pin inputs pass through a two-flop synchronizer and then an optional qualifier. The port shares one 8-bit sampling-period value across all pins. Zero means the synchronized level is passed straight on. A value k from 1 to 255 takes a sample every 2k clocks. A pin's qualified level then changes only once six samples in a row have agreed. Software and the peripherals see the same qualified level.

The qualifier is run by a two-state machine. QS_BYPASS is the reset state and passes the synchronized level through. QS_SAMPLE runs the sampling divider and the run filter. The transition ARM goes from QS_BYPASS to QS_SAMPLE when a non-zero period is written. The transition DISARM goes back when zero is written. Any write of the period restarts the sampling divider.

Top module: `gpio_qual_port`

## Requirements
- R1: A function-select bit of 1 drives that pin's pad output and output enable from the peripheral signals. A bit of 0 selects software (GPIO) control. After reset all function bits are 0. The function register is at address 0.
- R2: In GPIO mode the pad output enable equals the direction bit (1 = output). After reset all direction bits and all latch bits are 0. The direction register is at address 1.
- R3: A write to address 3 loads the output latch. A read of address 3 returns the qualified input level of every pin, not the latch.
- R4: A write to address 4 sets every latch bit written as 1 on the next clock and leaves the others unchanged. Reading address 4 returns 0.
- R5: A write to address 5 clears every latch bit written as 1 and leaves the others unchanged. Reading address 5 returns 0.
- R6: A write to address 6 inverts every latch bit written as 1 and leaves the others unchanged. Reading address 6 returns 0.
- R7: With a period of 0, a pad level that is stable before a clock edge appears at the qualified level after the second clock edge, through two synchronizer flops.
- R8: With a period k of 1 to 255, a sample is taken every 2k clocks, counted from the last period write. A pin's qualified level changes only on a sample at which it and the five samples before it all agree. A period write in the cycle a sample was due cancels that sample.
- R9: The peripheral input bus carries the same qualified level that address 3 returns.
- R10: Address 2 holds the 8-bit period in bits 7:0 and reads 0 above them. Addresses 0, 1 and 2 read back what was written, and address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| pad_in | input | 16 | Raw pad input levels |
| pad_out | output | 16 | Pad output levels |
| pad_oe | output | 16 | Pad output enables |
| periph_out | input | 16 | Peripheral output levels |
| periph_oe | input | 16 | Peripheral output enables |
| periph_in | output | 16 | Qualified input levels to peripherals |

## Verification
Two things can fall in the same cycle: a software rewrite of the sampling period, and the sample tick that the old period had scheduled for that cycle. The bench uses its own model's divider position to aim a period write at exactly the cycle when a tick is due. Pad levels are changed around that point, so a wrongly kept or lost tick shows up as a qualified level that moves early or late. Every cycle the model's pad, enable, peripheral-input and read-data values are compared with the design's. Directed checks with hand-worked values cover set, clear and toggle overlapping the latch, glitches shorter than six samples, and the switch between QS_BYPASS and QS_SAMPLE.

// File: rtl/gpq_pkg.sv
`timescale 1ns/1ps
package gpq_pkg;
    localparam int unsigned GPQ_AW = 3;

    typedef enum logic [GPQ_AW-1:0] {
        A_FUNC = 3'd0,
        A_DIR  = 3'd1,
        A_QPER = 3'd2,
        A_DATA = 3'd3,
        A_SET  = 3'd4,
        A_CLR  = 3'd5,
        A_TGL  = 3'd6,
        A_NONE = 3'd7
    } gpq_addr_e;

    typedef enum logic {
        QS_BYPASS = 1'b0,
        QS_SAMPLE = 1'b1
    } gpq_qstate_e;
endpackage

// File: rtl/gpq_regs.sv
`timescale 1ns/1ps
module gpq_regs
    import gpq_pkg::*;
#(
    parameter int unsigned W    = 16,
    parameter int unsigned PERW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [GPQ_AW-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      pin_level,
    output logic [W-1:0]      func_sel,
    output logic [W-1:0]      dir,
    output logic [W-1:0]      latch,
    output logic [PERW-1:0]   period,
    output logic              per_load,
    output logic [PERW-1:0]   per_val,
    output logic [W-1:0]      rdata
);
    gpq_addr_e       a_e;
    logic [W-1:0]    func_q, dir_q, lat_q;
    logic [PERW-1:0] per_q;

    assign a_e = gpq_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func_q <= '0;
            dir_q  <= '0;
            lat_q  <= '0;
            per_q  <= '0;
        end else if (wr_en) begin
            case (a_e)
                A_FUNC:  func_q <= wdata;
                A_DIR:   dir_q  <= wdata;
                A_QPER:  per_q  <= wdata[PERW-1:0];
                A_DATA:  lat_q  <= wdata;
                A_SET:   lat_q  <= lat_q | wdata;
                A_CLR:   lat_q  <= lat_q & ~wdata;
                A_TGL:   lat_q  <= lat_q ^ wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (a_e)
            A_FUNC:  rdata = func_q;
            A_DIR:   rdata = dir_q;
            A_QPER:  rdata = W'(per_q);
            A_DATA:  rdata = pin_level;
            default: rdata = '0;
        endcase
    end

    assign func_sel = func_q;
    assign dir      = dir_q;
    assign latch    = lat_q;
    assign period   = per_q;
    assign per_load = wr_en && (a_e == A_QPER);
    assign per_val  = wdata[PERW-1:0];

    assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a_e == A_SET) |=> ((lat_q & $past(wdata)) == $past(wdata)) &&
                                    ((lat_q & ~$past(wdata)) == ($past(lat_q) & ~$past(wdata))));
    assert_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a_e == A_CLR) |=> ((lat_q & $past(wdata)) == '0) &&
                                    ((lat_q & ~$past(wdata)) == ($past(lat_q) & ~$past(wdata))));
    assert_tgl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && a_e == A_TGL) |=> (lat_q == ($past(lat_q) ^ $past(wdata))));
    assert_lat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (a_e == A_DATA || a_e == A_SET || a_e == A_CLR || a_e == A_TGL))
        |=> $stable(lat_q));
endmodule

// File: rtl/gpq_sync.sv
`timescale 1ns/1ps
module gpq_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] ff1_q, ff2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ff1_q <= '0;
            ff2_q <= '0;
        end else begin
            ff1_q <= raw_i;
            ff2_q <= ff1_q;
        end
    end

    assign sync_o = ff2_q;
endmodule

// File: rtl/gpq_qual.sv
`timescale 1ns/1ps
module gpq_qual
    import gpq_pkg::*;
#(
    parameter int unsigned W    = 16,
    parameter int unsigned PERW = 8,
    parameter int unsigned RUN  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    sync_i,
    input  logic [PERW-1:0] period_i,
    input  logic            load_i,
    input  logic [PERW-1:0] load_val_i,
    output logic [W-1:0]    level_o
);
    localparam int unsigned CW = PERW + 1;

    gpq_qstate_e   state_q, state_d;
    logic [CW-1:0] cnt_q, limit;
    logic          tick;
    logic [W-1:0]  qual_q;
    logic [W-1:0]  agree;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= QS_BYPASS;
        else        state_q <= state_d;
    end

    // Transitions: ARM (bypass -> sample), DISARM (sample -> bypass)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            QS_BYPASS: if (load_i && load_val_i != '0) state_d = QS_SAMPLE;
            QS_SAMPLE: if (load_i && load_val_i == '0) state_d = QS_BYPASS;
        endcase
    end

    assign limit = {period_i, 1'b0} - CW'(1);
    assign tick  = (state_q == QS_SAMPLE) && !load_i && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i || state_q == QS_BYPASS || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CW'(1);
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic [RUN-1:0] hist_q;
        logic [RUN-1:0] window;

        assign window   = {hist_q[RUN-2:0], sync_i[i]};
        assign agree[i] = (&window) || !(|window);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hist_q    <= '0;
                qual_q[i] <= 1'b0;
            end else if (state_q == QS_BYPASS) begin
                hist_q    <= {RUN{sync_i[i]}};
                qual_q[i] <= sync_i[i];
            end else if (tick) begin
                hist_q <= window;
                if (agree[i]) qual_q[i] <= sync_i[i];
            end
        end

        assert_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == QS_SAMPLE && tick && !agree[i]) |=> $stable(qual_q[i]));
    end

    // Output process
    always_comb begin
        unique case (state_q)
            QS_BYPASS: level_o = sync_i;
            QS_SAMPLE: level_o = qual_q;
        endcase
    end

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == QS_SAMPLE) |-> (cnt_q <= limit));
    assert_qual_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == QS_SAMPLE && !tick) |=> $stable(qual_q));
endmodule

// File: rtl/gpio_qual_port.sv
`timescale 1ns/1ps
module gpio_qual_port
    import gpq_pkg::*;
#(
    parameter int unsigned PINS = 16,
    parameter int unsigned PERW = 8,
    parameter int unsigned RUN  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [GPQ_AW-1:0] addr,
    input  logic [PINS-1:0]   wdata,
    output logic [PINS-1:0]   rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    input  logic [PINS-1:0]   periph_out,
    input  logic [PINS-1:0]   periph_oe,
    output logic [PINS-1:0]   periph_in
);
    logic [PINS-1:0] func_sel, dir, latch, sync_lvl, level;
    logic [PERW-1:0] period, per_val;
    logic            per_load;

    gpq_regs #(.W(PINS), .PERW(PERW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .pin_level(level), .func_sel(func_sel), .dir(dir), .latch(latch),
        .period(period), .per_load(per_load), .per_val(per_val), .rdata(rdata)
    );

    gpq_sync #(.W(PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(pad_in), .sync_o(sync_lvl)
    );

    gpq_qual #(.W(PINS), .PERW(PERW), .RUN(RUN)) u_qual (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_lvl), .period_i(period),
        .load_i(per_load), .load_val_i(per_val), .level_o(level)
    );

    for (genvar i = 0; i < PINS; i++) begin : g_mux
        assign pad_out[i] = func_sel[i] ? periph_out[i] : latch[i];
        assign pad_oe[i]  = func_sel[i] ? periph_oe[i]  : dir[i];
    end

    assign periph_in = level;

    assert_gpio_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && gpq_addr_e'(addr) == A_DIR)
        |=> ((pad_oe & ~func_sel) == ($past(wdata) & ~func_sel)));
    assert_periph_oe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && gpq_addr_e'(addr) == A_FUNC)
        |=> ((pad_oe & func_sel) == (periph_oe & $past(wdata))));
endmodule

// File: tb/sim_gpio_qual_port.sv
`timescale 1ns/1ps
module sim_gpio_qual_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_wr = 1'b0;
    logic [2:0]  b_addr = 3'd0;
    logic [15:0] b_wd = '0, b_pin = '0, b_po = '0, b_poe = '0;
    logic [15:0] rdata, pad_out, pad_oe, periph_in;

    int nchk = 0, nfail = 0, ncyc = 0;

    // reference model state
    logic [15:0] m_func, m_dir, m_lat, s1, s2, mq;
    int          m_per, cnt;
    bit          m_byp;
    bit          last [16];
    int          run  [16];

    always #4 clk = ~clk;

    gpio_qual_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(b_wr), .addr(b_addr), .wdata(b_wd),
        .rdata(rdata), .pad_in(b_pin), .pad_out(pad_out), .pad_oe(pad_oe),
        .periph_out(b_po), .periph_oe(b_poe), .periph_in(periph_in)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] m_lvl();
        return m_byp ? s2 : mq;
    endfunction

    task automatic model_reset();
        m_func = '0; m_dir = '0; m_lat = '0; s1 = '0; s2 = '0; mq = '0;
        m_per = 0; cnt = 0; m_byp = 1;
        for (int i = 0; i < 16; i++) begin last[i] = 0; run[i] = 6; end
    endtask

    task automatic model_edge();
        bit load, tick;
        load = b_wr && b_addr == 3'd2;
        tick = !m_byp && !load && (cnt == 2 * m_per - 1);
        if (m_byp) begin
            for (int i = 0; i < 16; i++) begin last[i] = s2[i]; run[i] = 6; end
            mq = s2;
        end else if (tick) begin
            for (int i = 0; i < 16; i++) begin
                if (s2[i] == last[i]) run[i] = (run[i] < 6) ? run[i] + 1 : 6;
                else begin run[i] = 1; last[i] = s2[i]; end
                if (run[i] >= 6) mq[i] = s2[i];
            end
        end
        if (load || m_byp || tick) cnt = 0; else cnt++;
        if (load) m_byp = (b_wd[7:0] == 8'd0);
        s2 = s1; s1 = b_pin;
        if (b_wr) begin
            case (b_addr)
                3'd0: m_func = b_wd;
                3'd1: m_dir  = b_wd;
                3'd2: m_per  = int'(b_wd[7:0]);
                3'd3: m_lat  = b_wd;
                3'd4: m_lat  = m_lat | b_wd;
                3'd5: m_lat  = m_lat & ~b_wd;
                3'd6: m_lat  = m_lat ^ b_wd;
                default: ;
            endcase
        end
    endtask

    task automatic compare_all();
        logic [15:0] er;
        chk("R1 pad_out", pad_out, (m_func & b_po) | (~m_func & m_lat));
        chk("R2 pad_oe", pad_oe, (m_func & b_poe) | (~m_func & m_dir));
        chk(m_byp ? "R9/R7 periph_in" : "R9/R8 periph_in", periph_in, m_lvl());
        case (b_addr)
            3'd0: er = m_func;
            3'd1: er = m_dir;
            3'd2: er = 16'(m_per);
            3'd3: er = m_lvl();
            default: er = '0;
        endcase
        case (b_addr)
            3'd3: chk("R3 rdata", rdata, er);
            3'd4: chk("R4 rdata", rdata, er);
            3'd5: chk("R5 rdata", rdata, er);
            3'd6: chk("R6 rdata", rdata, er);
            default: chk("R10 rdata", rdata, er);
        endcase
    endtask

    // one cycle: compare after settling, clock, update model, return at negedge
    task automatic step();
        #1 compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic wreg(input logic [2:0] a, input logic [15:0] d);
        b_wr = 1; b_addr = a; b_wd = d;
        step();
        b_wr = 0; b_wd = '0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [15:0] exp);
        b_addr = a;
        #1 chk(tag, rdata, exp);
        step();
    endtask

    always @(posedge clk) begin
        ncyc++;
        if (ncyc > 150000) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", ncyc);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // reset state
        #1 chk("R2 reset oe", pad_oe, 16'h0000);
        chk("R2 reset latch", pad_out, 16'h0000);
        rd_chk("R1 reset func", 3'd0, 16'h0000);
        // latch and direction
        wreg(3'd1, 16'hFFFF);
        wreg(3'd3, 16'hA5A5);
        #1 chk("R3 latch drive", pad_out, 16'hA5A5);
        wreg(3'd4, 16'h0F00);
        #1 chk("R4 set", pad_out, 16'hAFA5);
        wreg(3'd5, 16'h0005);
        #1 chk("R5 clear", pad_out, 16'hAFA0);
        wreg(3'd6, 16'hFFFF);
        #1 chk("R6 toggle", pad_out, 16'h505F);
        wreg(3'd4, 16'h0000); wreg(3'd5, 16'h0000); wreg(3'd6, 16'h0000);
        #1 chk("R4 zero bits ignored", pad_out, 16'h505F);
        rd_chk("R4 read zero", 3'd4, 16'h0000);
        rd_chk("R5 read zero", 3'd5, 16'h0000);
        rd_chk("R6 read zero", 3'd6, 16'h0000);
        rd_chk("R10 unused addr", 3'd7, 16'h0000);
        // peripheral function
        b_po = 16'h1234; b_poe = 16'h0F0F;
        wreg(3'd1, 16'hFFFF);
        wreg(3'd0, 16'hF0F0);
        #1 chk("R1 periph out", pad_out, 16'h103F);
        chk("R1 periph oe", pad_oe, 16'h0F0F);
        rd_chk("R10 func readback", 3'd0, 16'hF0F0);
        wreg(3'd0, 16'h0000);
        // period 0: two-flop latency
        b_addr = 3'd3; b_pin = 16'hBEEF;
        step();
        #1 chk("R7 after 1 edge", rdata, 16'h0000);
        step();
        #1 chk("R7 after 2 edges", rdata, 16'hBEEF);
        chk("R9 periph_in", periph_in, 16'hBEEF);
        // period 1: glitch filter
        wreg(3'd2, 16'hFF01);
        rd_chk("R10 period upper zero", 3'd2, 16'h0001);
        b_pin = 16'hFFFF; idle(20);
        rd_chk("R8 settle high", 3'd3, 16'hFFFF);
        b_pin = 16'h0000; idle(6);
        b_pin = 16'hFFFF; idle(20);
        rd_chk("R8 short glitch rejected", 3'd3, 16'hFFFF);
        b_pin = 16'h0000; idle(20);
        rd_chk("R8 long low accepted", 3'd3, 16'h0000);
        // period rewrite colliding with a due tick
        wreg(3'd2, 16'h0004);
        b_pin = 16'h00FF; idle(30);
        for (int r = 0; r < 3; r++) begin
            while (cnt != 2 * m_per - 1) step();
            b_pin = ~b_pin;
            wreg(3'd2, 16'h0004);
            idle(5);
        end
        idle(80);
        // largest period
        wreg(3'd2, 16'h00FF);
        b_pin = 16'h0001; b_addr = 3'd3; idle(3700);
        rd_chk("R8 max period", 3'd3, 16'h0001);
        // back to bypass
        b_pin = 16'h8000;
        wreg(3'd2, 16'h0000);
        idle(2);
        rd_chk("R7 bypass again", 3'd3, 16'h8000);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule